// File: doc/BRIEF.md
# Windowed Address Partition Translator

This block turns a wide, fixed virtual address into an offset inside a compact physical device address space. It has four programmable windows: a first memory window, a register window, a second memory window and a third memory window. The physical images of these windows sit back to back. Each window's physical base is therefore the sum of the sizes of the windows that come before it in the fixed checking order.

Software loads each window's start and size into shadow registers through a simple write port. The fourth window's size cannot be written: the block derives it from the total physical size, given as a parameter. A commit strobe moves the whole shadow set into the active set in one clock edge.

The lookup is combinational and returns the physical offset and a hit flag in the same cycle. A qualified lookup that misses every window sets a sticky error bit, which software clears.

Top module: `addr_window_xlate`

## Requirements
- R1: Windows are tested in the fixed order window 0 (first memory), window 1 (register), window 2 (second memory), window 3 (third memory). When an address lies in more than one window, the earliest window in that order alone decides the result.
- R2: An address hits a window when it is at least the window's start and strictly below start plus size, with the end computed without wrap-around. A window of size zero never hits.
- R3: On a hit in window k, `lk_phys` equals the address minus window k's start, plus the sum of the active sizes of windows 0 to k-1, taken modulo 2^AW. For window 0 the added sum is zero.
- R4: An address that hits no window gives `lk_hit`=0 and `lk_phys`=0.
- R5: The active size of window 3 equals PHYS_TOTAL minus the sum of the committed sizes of windows 0 to 2. When that sum is PHYS_TOTAL or more, the size is zero.
- R6: `cfg_sel` is {window index[1:0], field}, where field 0 is start and field 1 is size. For example, sel 3 is the size of window 1 and sel 6 is the start of window 3. A write with sel 7, the size slot of window 3, is ignored.
- R7: Configuration writes change only the shadow set. The active set, and with it every lookup result, changes only at a clock edge where `cfg_commit` is 1, and then all fields change together.
- R8: A clock edge with `lk_valid`=1 and `lk_hit`=0 sets `err_sticky`, which is visible from the next cycle. If `err_clr` is asserted at the same edge, setting still wins.
- R9: A clock edge with `err_clr`=1 and no qualified miss clears `err_sticky`. Otherwise the bit holds its value.
- R10: Synchronous reset clears the shadow and active starts and sizes, and sets the active size of window 3 to PHYS_TOTAL. After reset, addresses in [0, PHYS_TOTAL) map to themselves with a hit, and `err_sticky` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Shadow configuration write enable |
| cfg_sel | input | 3 | Field select {window[1:0], start=0/size=1} |
| cfg_wdata | input | AW | Value written to the selected shadow field |
| cfg_commit | input | 1 | Copies the shadow set into the active set |
| lk_addr | input | AW | Virtual address to translate |
| lk_valid | input | 1 | Qualifies the lookup for error recording |
| err_clr | input | 1 | Clears the sticky out-of-range bit |
| lk_phys | output | AW | Translated physical offset (0 on a miss) |
| lk_hit | output | 1 | Address fell in one of the windows |
| err_sticky | output | 1 | A qualified lookup missed since the last clear |

## Verification
Wrong active state, such as a bad base sum or a derived size that does not saturate, shows up in `lk_phys` and `lk_hit` in the same cycle as the lookup. It is seen first at window edges and for addresses in the later windows, whose bases add up every earlier size. A shadow value leaking into the active set before commit appears as a changed translation before any commit strobe. Faults in the sticky bit appear one cycle after a qualified miss or a clear, and most sharply when both happen at the same edge.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int NWIN = 4;
  localparam int WSEL = $clog2(NWIN);
  typedef enum logic {FLD_START = 1'b0, FLD_SIZE = 1'b1} fld_e;
endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs
  import xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] PHYS_TOTAL = 32'h0002_0000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [WSEL:0]             sel,
  input  logic [AW-1:0]             wdata,
  input  logic                      commit,
  output logic [NWIN-1:0][AW-1:0]   act_start,
  output logic [NWIN-1:0][AW-1:0]   act_size,
  output logic [NWIN-1:0][AW-1:0]   act_base
);
  localparam int SW = AW + 2;

  logic [NWIN-1:0][AW-1:0] sh_start;
  logic [NWIN-2:0][AW-1:0] sh_size;
  logic [NWIN-1:0][SW-1:0] prefix;
  logic [AW-1:0]           last_size;
  logic [WSEL-1:0]         win;
  fld_e                    fld;

  assign win = sel[WSEL:1];
  assign fld = fld_e'(sel[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_start <= '0;
      sh_size  <= '0;
    end else if (we) begin
      for (int i = 0; i < NWIN; i++) begin
        if (win == WSEL'(i)) begin
          if (fld == FLD_START) sh_start[i] <= wdata;
          else if (i < NWIN - 1) sh_size[i] <= wdata;
        end
      end
    end
  end

  always_comb begin
    prefix[0] = '0;
    for (int i = 1; i < NWIN; i++)
      prefix[i] = prefix[i-1] + SW'(sh_size[i-1]);
  end

  assign last_size = (prefix[NWIN-1] >= SW'(PHYS_TOTAL)) ? '0
                   : PHYS_TOTAL - prefix[NWIN-1][AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_start <= '0;
      act_base  <= '0;
      act_size  <= '0;
      act_size[NWIN-1] <= PHYS_TOTAL;
    end else if (commit) begin
      act_start <= sh_start;
      for (int i = 0; i < NWIN; i++) begin
        act_base[i] <= prefix[i][AW-1:0];
        if (i < NWIN - 1) act_size[i] <= sh_size[i];
      end
      act_size[NWIN-1] <= last_size;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(act_start) && $stable(act_size) && $stable(act_base)));

  assert_sat_R5: assert property (@(posedge clk) disable iff (rst)
    act_size[NWIN-1] <= PHYS_TOTAL);
endmodule

// File: rtl/xlate_window.sv
module xlate_window #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] size,
  input  logic [AW-1:0] base,
  output logic          hit,
  output logic [AW-1:0] phys
);
  logic [AW:0] win_end;

  assign win_end = {1'b0, start} + {1'b0, size};
  assign hit     = (addr >= start) && ({1'b0, addr} < win_end);
  assign phys    = addr - start + base;
endmodule

// File: rtl/xlate_prio_sel.sv
module xlate_prio_sel
  import xlate_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NWIN-1:0]         hits,
  input  logic [NWIN-1:0][AW-1:0] phys_in,
  output logic                    hit,
  output logic [AW-1:0]           phys
);
  logic [NWIN-1:0] grant;
  logic            found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    phys  = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (hits[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        phys     = phys_in[i];
      end
    end
  end

  assign hit = |hits;

  assert_single_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (hit == (grant != '0)));
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] PHYS_TOTAL = 32'h0002_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [WSEL:0] cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          cfg_commit,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_valid,
  input  logic          err_clr,
  output logic [AW-1:0] lk_phys,
  output logic          lk_hit,
  output logic          err_sticky
);
  logic [NWIN-1:0][AW-1:0] act_start;
  logic [NWIN-1:0][AW-1:0] act_size;
  logic [NWIN-1:0][AW-1:0] act_base;
  logic [NWIN-1:0]         w_hit;
  logic [NWIN-1:0][AW-1:0] w_phys;
  logic                    miss;

  xlate_cfg_regs #(.AW(AW), .PHYS_TOTAL(PHYS_TOTAL)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .commit(cfg_commit), .act_start(act_start), .act_size(act_size),
    .act_base(act_base)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    xlate_window #(.AW(AW)) u_win (
      .addr(lk_addr), .start(act_start[g]), .size(act_size[g]),
      .base(act_base[g]), .hit(w_hit[g]), .phys(w_phys[g])
    );
  end

  xlate_prio_sel #(.AW(AW)) u_sel (
    .clk(clk), .rst(rst), .hits(w_hit), .phys_in(w_phys),
    .hit(lk_hit), .phys(lk_phys)
  );

  assign miss = lk_valid && !lk_hit;

  always_ff @(posedge clk) begin
    if (rst)          err_sticky <= 1'b0;
    else if (miss)    err_sticky <= 1'b1;
    else if (err_clr) err_sticky <= 1'b0;
  end

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_phys == '0));

  assert_err_set_R8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_hit) |=> err_sticky);

  assert_err_clr_R9: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !(lk_valid && !lk_hit)) |=> !err_sticky);
endmodule

// File: tb/tb_addr_window_xlate.sv
module tb_addr_window_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [AW-1:0] TOTAL = 32'h0002_0000;
  localparam int NV = 12;

  // {addr, expected phys, expected hit} for the main configuration
  localparam logic [64:0] VEC [NV] = '{
    {32'h1000_0000, 32'h0000_0000, 1'b1},
    {32'h1000_3FFF, 32'h0000_3FFF, 1'b1},
    {32'h1000_4000, 32'h0000_0000, 1'b0},
    {32'h0030_0000, 32'h0000_4000, 1'b1},
    {32'h0030_0FFF, 32'h0000_4FFF, 1'b1},
    {32'h0040_0010, 32'h0000_5010, 1'b1},
    {32'h0040_2000, 32'h0000_0000, 1'b0},
    {32'h0050_0000, 32'h0000_7000, 1'b1},
    {32'h0051_8FFF, 32'h0001_FFFF, 1'b1},
    {32'h0051_9000, 32'h0000_0000, 1'b0},
    {32'h0FFF_FFFF, 32'h0000_0000, 1'b0},
    {32'h002F_FFFF, 32'h0000_0000, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          cfg_commit = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_valid = 1'b0;
  logic          err_clr = 1'b0;
  logic [AW-1:0] lk_phys;
  logic          lk_hit;
  logic          err_sticky;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_xlate #(.AW(AW), .PHYS_TOTAL(TOTAL)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit), .lk_addr(lk_addr),
    .lk_valid(lk_valid), .err_clr(err_clr), .lk_phys(lk_phys),
    .lk_hit(lk_hit), .err_sticky(err_sticky)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
  endtask

  task automatic look(input string tag, input logic [AW-1:0] a,
                      input logic [AW-1:0] ephys, input logic ehit);
    @(negedge clk);
    lk_addr = a;
    #1;
    check({tag, " hit"}, AW'(lk_hit), AW'(ehit));
    check({tag, " phys"}, lk_phys, ephys);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state, identity mapping through window 3
    look("R10 in-range", 32'h0000_0100, 32'h0000_0100, 1'b1);
    look("R10 edge", TOTAL, 32'h0, 1'b0);
    check("R10 err", AW'(err_sticky), 32'h0);

    // main configuration (R6 encoding)
    wr(3'd0, 32'h1000_0000); wr(3'd1, 32'h0000_4000);
    wr(3'd2, 32'h0030_0000); wr(3'd3, 32'h0000_1000);
    wr(3'd4, 32'h0040_0000); wr(3'd5, 32'h0000_2000);
    wr(3'd6, 32'h0050_0000);
    // R7: nothing visible before commit
    look("R7 precommit", 32'h1000_0000, 32'h0, 1'b0);
    look("R7 precommit old", 32'h0000_0100, 32'h0000_0100, 1'b1);
    commit();

    // R2 R3 R4 R5: vector table
    for (int i = 0; i < NV; i++)
      look("R2/R3/R4/R5 vec", VEC[i][64:33], VEC[i][32:1], VEC[i][0]);

    // R7: shadow change held until commit
    wr(3'd0, 32'h2000_0000);
    look("R7 held", 32'h1000_0000, 32'h0, 1'b1);
    commit();
    look("R7 new", 32'h2000_0010, 32'h0000_0010, 1'b1);
    look("R7 old gone", 32'h1000_0000, 32'h0, 1'b0);

    // R1: overlap, window 0 wins over window 1
    wr(3'd2, 32'h2000_2000);
    commit();
    look("R1 overlap", 32'h2000_2000, 32'h0000_2000, 1'b1);

    // R6: size slot of window 3 is ignored
    wr(3'd7, 32'h0000_0000);
    commit();
    look("R6 ignored", 32'h0050_0000, 32'h0000_7000, 1'b1);
    look("R6 ignored end", 32'h0051_8FFF, 32'h0001_FFFF, 1'b1);

    // R5: saturation of the derived size
    wr(3'd1, 32'h0001_0000); wr(3'd3, 32'h0001_0000); wr(3'd5, 32'h0000_8000);
    commit();
    look("R5 sat", 32'h0050_0000, 32'h0, 1'b0);
    look("R3 far base", 32'h0040_7FFF, 32'h0002_7FFF, 1'b1);

    // R8: qualified miss sets sticky bit
    @(negedge clk);
    lk_addr = 32'hFFFF_0000; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R8 set", AW'(err_sticky), 32'h1);
    // R9: clear
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check("R9 clear", AW'(err_sticky), 32'h0);
    // R9: unqualified miss leaves it clear
    @(negedge clk);
    check("R9 hold", AW'(err_sticky), 32'h0);
    // R8: set wins over clear
    lk_valid = 1'b1; err_clr = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0; err_clr = 1'b0;
    check("R8 set wins", AW'(err_sticky), 32'h1);
    // R8: qualified hit does not set
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    lk_addr = 32'h0040_0000; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R8 hit no set", AW'(err_sticky), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule